// File: doc/BRIEF.md
# Program Counter Sequencing Unit

This block works out where execution goes next after a control-transfer instruction of a small 8-bit processor. Each accepted operation carries the current program counter, an operation code, a signed 12-bit relative offset, a 22-bit absolute target, the 16-bit Z pointer, a skip condition and a flag that says whether the following instruction occupies two words. One clock later the block presents the next program counter, any stack push (with its return address) or stack pop, a flag that re-enables interrupts, and the number of cycles the instruction takes.

The stack memory and instruction fetch lie outside the block. For returns, the word that would be popped is offered on `stack_top_i` in the same cycle as the operation. All program-counter arithmetic wraps modulo 2^PC_W, the size of program memory in words.

Top module: `pc_seq_unit`

## Requirements
- R1: During and after reset, before any operation is accepted, `valid_o`, `push_o`, `pop_o` and `ie_set_o` are 0, and `next_pc_o` and `cycles_o` are 0.
- R2: An operation presented with `valid_i`=1 at a rising edge drives `valid_o`=1 and all results in the following cycle. After a cycle with `valid_i`=0, `valid_o`, `push_o` and `pop_o` are 0 and `next_pc_o` keeps its value.
- R3: Code 0 (relative jump) gives next PC = pc + k + 1, where k is `offset_i` read as signed, modulo 2^PC_W. It takes 2 cycles and causes no stack traffic.
- R4: Code 1 (absolute jump) gives next PC = the low PC_W bits of `target_i`. It takes 3 cycles and causes no stack traffic.
- R5: Code 2 (indirect jump) gives next PC = `zptr_i`, zero-extended or truncated to PC_W. It takes 2 cycles and causes no stack traffic.
- R6: Code 3 (relative call) pushes pc+1 and gives next PC = pc + k + 1. It takes 3 cycles.
- R7: Code 4 (absolute call) pushes pc+2 (modulo 2^PC_W) and gives next PC = the low PC_W bits of `target_i`. It takes 4 cycles.
- R8: Code 5 (indirect call) pushes pc+1 and gives next PC = `zptr_i`. It takes 3 cycles.
- R9: Code 6 (return) pops and gives next PC = `stack_top_i`. It takes 4 cycles and leaves `ie_set_o`=0.
- R10: Code 7 (interrupt return) behaves as a return and also drives `ie_set_o`=1.
- R11: Code 8 (skip) with `skip_cond_i`=0 gives pc+1 in 1 cycle. With the condition true it gives pc+2 in 2 cycles when `next_long_i`=0, and pc+3 in 3 cycles when `next_long_i`=1. No stack traffic.
- R12: Codes 9 to 15 advance to pc+1 in 1 cycle with no stack traffic.
- R13: `push_o` and `pop_o` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 4 | Operation code |
| pc_i | input | PC_W | Current program counter |
| offset_i | input | OFS_W | Signed relative offset |
| target_i | input | ABS_W | Absolute target |
| zptr_i | input | PTR_W | Z pointer |
| skip_cond_i | input | 1 | Skip condition is true |
| next_long_i | input | 1 | Following instruction is two words |
| stack_top_i | input | PC_W | Word that a pop returns |
| valid_o | output | 1 | Results valid |
| next_pc_o | output | PC_W | Next program counter |
| push_o | output | 1 | Push request |
| push_addr_o | output | PC_W | Return address to push |
| pop_o | output | 1 | Pop request |
| ie_set_o | output | 1 | Set global interrupt enable |
| cycles_o | output | 3 | Instruction cycle count |

## Verification
The bench builds the unit with PC_W=12, so that the offset range of ±2048 covers the whole 4096-word space. This puts wrap-around in both directions within reach, with offsets at both ends of the range. The same width makes the 22-bit absolute target and the 16-bit Z pointer lose their upper bits, which checks truncation. It also lets the pc+2 return address of an absolute call wrap when issued from the top two words.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam int CYC_W = 3;

  typedef enum logic [3:0] {
    OP_JREL = 4'd0,
    OP_JABS = 4'd1,
    OP_JIND = 4'd2,
    OP_CREL = 4'd3,
    OP_CABS = 4'd4,
    OP_CIND = 4'd5,
    OP_RET  = 4'd6,
    OP_RETI = 4'd7,
    OP_SKIP = 4'd8
  } pc_op_e;

  typedef enum logic [1:0] {
    STK_NONE = 2'd0,
    STK_PUSH = 2'd1,
    STK_POP  = 2'd2
  } stk_e;
endpackage

// File: rtl/pcs_target.sv
module pcs_target #(
  parameter int PC_W  = 16,
  parameter int OFS_W = 12,
  parameter int ABS_W = 22,
  parameter int PTR_W = 16
) (
  input  logic [3:0]       op_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [OFS_W-1:0] offset_i,
  input  logic [ABS_W-1:0] target_i,
  input  logic [PTR_W-1:0] zptr_i,
  input  logic             skip_cond_i,
  input  logic             next_long_i,
  input  logic [PC_W-1:0]  stack_top_i,
  output logic [PC_W-1:0]  next_pc_o,
  output logic [PC_W-1:0]  ret_addr_o
);
  import pcs_pkg::*;

  localparam int EXT_W = (PC_W > OFS_W) ? PC_W : OFS_W;

  logic [EXT_W-1:0] ofs_ext;
  logic [PC_W-1:0]  pc_inc1, pc_inc2, pc_inc3, rel_tgt, abs_tgt, ind_tgt;

  assign ofs_ext = EXT_W'($signed(offset_i));
  assign pc_inc1 = pc_i + PC_W'(1);
  assign pc_inc2 = pc_i + PC_W'(2);
  assign pc_inc3 = pc_i + PC_W'(3);
  assign rel_tgt = pc_inc1 + ofs_ext[PC_W-1:0];  // wraps mod 2^PC_W
  assign abs_tgt = PC_W'(target_i);
  assign ind_tgt = PC_W'(zptr_i);

  always_comb begin
    unique case (op_i)
      OP_JREL, OP_CREL: next_pc_o = rel_tgt;
      OP_JABS, OP_CABS: next_pc_o = abs_tgt;
      OP_JIND, OP_CIND: next_pc_o = ind_tgt;
      OP_RET,  OP_RETI: next_pc_o = stack_top_i;
      OP_SKIP:          next_pc_o = !skip_cond_i ? pc_inc1 :
                                    (next_long_i ? pc_inc3 : pc_inc2);
      default:          next_pc_o = pc_inc1;
    endcase
  end

  // two-word call returns past its second word
  assign ret_addr_o = (op_i == OP_CABS) ? pc_inc2 : pc_inc1;
endmodule

// File: rtl/pcs_cost.sv
module pcs_cost (
  input  logic                   op_valid_i,
  input  logic [3:0]             op_i,
  input  logic                   skip_cond_i,
  input  logic                   next_long_i,
  output logic [pcs_pkg::CYC_W-1:0] cycles_o,
  output pcs_pkg::stk_e          stk_o,
  output logic                   ie_set_o
);
  import pcs_pkg::*;

  always_comb begin
    stk_o    = STK_NONE;
    ie_set_o = 1'b0;
    unique case (op_i)
      OP_JREL, OP_JIND: cycles_o = CYC_W'(2);
      OP_JABS:          cycles_o = CYC_W'(3);
      OP_CREL, OP_CIND: begin cycles_o = CYC_W'(3); stk_o = STK_PUSH; end
      OP_CABS:          begin cycles_o = CYC_W'(4); stk_o = STK_PUSH; end
      OP_RET:           begin cycles_o = CYC_W'(4); stk_o = STK_POP;  end
      OP_RETI:          begin cycles_o = CYC_W'(4); stk_o = STK_POP; ie_set_o = 1'b1; end
      OP_SKIP:          cycles_o = !skip_cond_i ? CYC_W'(1) :
                                   (next_long_i ? CYC_W'(3) : CYC_W'(2));
      default:          cycles_o = CYC_W'(1);
    endcase
    if (!op_valid_i) begin
      stk_o    = STK_NONE;
      ie_set_o = 1'b0;
    end
  end
endmodule

// File: rtl/pc_seq_unit.sv
module pc_seq_unit #(
  parameter int PC_W  = 16,
  parameter int OFS_W = 12,
  parameter int ABS_W = 22,
  parameter int PTR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [3:0]       op_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [OFS_W-1:0] offset_i,
  input  logic [ABS_W-1:0] target_i,
  input  logic [PTR_W-1:0] zptr_i,
  input  logic             skip_cond_i,
  input  logic             next_long_i,
  input  logic [PC_W-1:0]  stack_top_i,
  output logic             valid_o,
  output logic [PC_W-1:0]  next_pc_o,
  output logic             push_o,
  output logic [PC_W-1:0]  push_addr_o,
  output logic             pop_o,
  output logic             ie_set_o,
  output logic [2:0]       cycles_o
);
  import pcs_pkg::*;

  logic [PC_W-1:0]  nxt_pc, ret_addr;
  logic [CYC_W-1:0] cyc;
  stk_e             stk;
  logic             ie_set;

  pcs_target #(
    .PC_W(PC_W), .OFS_W(OFS_W), .ABS_W(ABS_W), .PTR_W(PTR_W)
  ) u_target (
    .op_i        (op_i),
    .pc_i        (pc_i),
    .offset_i    (offset_i),
    .target_i    (target_i),
    .zptr_i      (zptr_i),
    .skip_cond_i (skip_cond_i),
    .next_long_i (next_long_i),
    .stack_top_i (stack_top_i),
    .next_pc_o   (nxt_pc),
    .ret_addr_o  (ret_addr)
  );

  pcs_cost u_cost (
    .op_valid_i  (valid_i),
    .op_i        (op_i),
    .skip_cond_i (skip_cond_i),
    .next_long_i (next_long_i),
    .cycles_o    (cyc),
    .stk_o       (stk),
    .ie_set_o    (ie_set)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      next_pc_o   <= '0;
      push_o      <= 1'b0;
      push_addr_o <= '0;
      pop_o       <= 1'b0;
      ie_set_o    <= 1'b0;
      cycles_o    <= '0;
    end else begin
      valid_o  <= valid_i;
      push_o   <= (stk == STK_PUSH);
      pop_o    <= (stk == STK_POP);
      ie_set_o <= ie_set;
      if (valid_i) begin
        next_pc_o   <= nxt_pc;
        push_addr_o <= ret_addr;
        cycles_o    <= cyc;
      end
    end
  end

  assert_excl_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_o && pop_o));
  assert_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (!push_o && !pop_o && !ie_set_o));
  assert_lat_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(next_pc_o));
  assert_ie_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ie_set_o |-> (pop_o && cycles_o == 3'd4));
  assert_pop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd6) |=> (pop_o && next_pc_o == $past(stack_top_i)));
  assert_push_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> (cycles_o == 3'd3 || cycles_o == 3'd4));
endmodule

// File: tb/sim_pc_seq_unit.sv
`timescale 1ns/1ps
module sim_pc_seq_unit;
  localparam int PW = 12;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            valid_i = 1'b0;
  logic [3:0]      op_i = '0;
  logic [PW-1:0]   pc_i = '0;
  logic [11:0]     offset_i = '0;
  logic [21:0]     target_i = '0;
  logic [15:0]     zptr_i = '0;
  logic            skip_cond_i = 1'b0;
  logic            next_long_i = 1'b0;
  logic [PW-1:0]   stack_top_i = '0;
  logic            valid_o, push_o, pop_o, ie_set_o;
  logic [PW-1:0]   next_pc_o, push_addr_o;
  logic [2:0]      cycles_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pc_seq_unit #(.PC_W(PW), .OFS_W(12), .ABS_W(22), .PTR_W(16)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .op_i(op_i), .pc_i(pc_i),
    .offset_i(offset_i), .target_i(target_i), .zptr_i(zptr_i),
    .skip_cond_i(skip_cond_i), .next_long_i(next_long_i),
    .stack_top_i(stack_top_i), .valid_o(valid_o), .next_pc_o(next_pc_o),
    .push_o(push_o), .push_addr_o(push_addr_o), .pop_o(pop_o),
    .ie_set_o(ie_set_o), .cycles_o(cycles_o)
  );

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic string req_of(logic [3:0] op);
    case (op)
      4'd0: return "R3";  4'd1: return "R4";  4'd2: return "R5";
      4'd3: return "R6";  4'd4: return "R7";  4'd5: return "R8";
      4'd6: return "R9";  4'd7: return "R10"; 4'd8: return "R11";
      default: return "R12";
    endcase
  endfunction

  // drive at negedge, result visible at the following negedge
  task automatic run_op(logic [3:0] op, logic [PW-1:0] pc, logic [11:0] k,
                        logic [21:0] tgt, logic [15:0] z, logic sc, logic lng,
                        logic [PW-1:0] st);
    logic [PW-1:0] e_pc, e_addr;
    logic e_push, e_pop, e_ie;
    int e_cyc;
    string r;
    e_push = 0; e_pop = 0; e_ie = 0; e_addr = pc + 12'd1;
    case (op)
      4'd0: begin e_pc = pc + k + 12'd1; e_cyc = 2; end
      4'd1: begin e_pc = tgt[PW-1:0]; e_cyc = 3; end
      4'd2: begin e_pc = z[PW-1:0]; e_cyc = 2; end
      4'd3: begin e_pc = pc + k + 12'd1; e_cyc = 3; e_push = 1; end
      4'd4: begin e_pc = tgt[PW-1:0]; e_cyc = 4; e_push = 1; e_addr = pc + 12'd2; end
      4'd5: begin e_pc = z[PW-1:0]; e_cyc = 3; e_push = 1; end
      4'd6: begin e_pc = st; e_cyc = 4; e_pop = 1; end
      4'd7: begin e_pc = st; e_cyc = 4; e_pop = 1; e_ie = 1; end
      4'd8: begin
        if (!sc) begin e_pc = pc + 12'd1; e_cyc = 1; end
        else if (lng) begin e_pc = pc + 12'd3; e_cyc = 3; end
        else begin e_pc = pc + 12'd2; e_cyc = 2; end
      end
      default: begin e_pc = pc + 12'd1; e_cyc = 1; end
    endcase
    @(negedge clk);
    valid_i = 1; op_i = op; pc_i = pc; offset_i = k; target_i = tgt;
    zptr_i = z; skip_cond_i = sc; next_long_i = lng; stack_top_i = st;
    @(negedge clk);
    valid_i = 0;
    r = req_of(op);
    chk("R2", "valid_o", valid_o, 1);
    chk(r, "next_pc", next_pc_o, e_pc);
    chk(r, "cycles", cycles_o, e_cyc);
    chk(r, "push", push_o, e_push);
    chk(r, "pop", pop_o, e_pop);
    chk(r, "ie_set", ie_set_o, e_ie);
    if (e_push) chk(r, "push_addr", push_addr_o, e_addr);
    chk("R13", "push&pop", push_o & pop_o, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [PW-1:0] held;
    void'($urandom(32'd1234));
    #20;
    chk("R1", "valid_o", valid_o, 0);
    chk("R1", "push", push_o, 0);
    chk("R1", "pop", pop_o, 0);
    chk("R1", "ie_set", ie_set_o, 0);
    chk("R1", "next_pc", next_pc_o, 0);
    chk("R1", "cycles", cycles_o, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("R1", "valid_o after release", valid_o, 0);

    // directed corners
    run_op(4'd0, 12'd0,    12'h800, '0, '0, 0, 0, '0);      // R3 -2048 wraps low
    run_op(4'd0, 12'd4095, 12'h7FF, '0, '0, 0, 0, '0);      // R3 +2047 wraps high
    run_op(4'd0, 12'd100,  12'hFFF, '0, '0, 0, 0, '0);      // R3 k=-1 -> self
    run_op(4'd1, 12'd5, '0, 22'h3FFFFF, '0, 0, 0, '0);      // R4 truncation
    run_op(4'd2, 12'd5, '0, '0, 16'hABCD, 0, 0, '0);        // R5 truncation
    run_op(4'd3, 12'd4095, 12'd10, '0, '0, 0, 0, '0);       // R6 push wraps
    run_op(4'd4, 12'd4094, '0, 22'h000123, '0, 0, 0, '0);   // R7 push pc+2 = 0
    run_op(4'd4, 12'd4095, '0, 22'h000123, '0, 0, 0, '0);   // R7 push pc+2 = 1
    run_op(4'd5, 12'd77, '0, '0, 16'h0FFF, 0, 0, '0);       // R8
    run_op(4'd6, 12'd9, '0, '0, '0, 0, 0, 12'd3333);        // R9
    run_op(4'd7, 12'd9, '0, '0, '0, 0, 0, 12'd1234);        // R10
    run_op(4'd8, 12'd4094, '0, '0, '0, 0, 1, '0);           // R11 false
    run_op(4'd8, 12'd4094, '0, '0, '0, 1, 0, '0);           // R11 short
    run_op(4'd8, 12'd4094, '0, '0, '0, 1, 1, '0);           // R11 long, wraps
    run_op(4'd9, 12'd4095, '0, '0, '0, 1, 1, '0);           // R12
    run_op(4'd15, 12'd20, 12'd5, '0, '0, 0, 0, '0);         // R12

    // idle cycle: no valid, no stack, pc held (R2)
    held = next_pc_o;
    @(negedge clk);
    chk("R2", "idle valid_o", valid_o, 0);
    chk("R2", "idle push", push_o, 0);
    chk("R2", "idle pop", pop_o, 0);
    chk("R2", "idle next_pc held", next_pc_o, held);

    // a pop followed by idle must not leave pop asserted (R2)
    run_op(4'd7, 12'd1, '0, '0, '0, 0, 0, 12'd55);
    @(negedge clk);
    chk("R2", "pop dropped", pop_o, 0);
    chk("R10", "ie dropped", ie_set_o, 0);

    for (int i = 0; i < 400; i++) begin
      run_op(4'($urandom % 16), PW'($urandom), 12'($urandom), 22'($urandom),
             16'($urandom), 1'($urandom), 1'($urandom), PW'($urandom));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule